// File: doc/BRIEF.md
# I2C Master Receive Sequencer

This block carries an I2C controller through the data phase of a master read. Once a START has been placed on the bus, it clocks in bytes MSB first. After each byte it drives an acknowledge or a not-acknowledge, as software selects. It then raises an interrupt flag, posts a status code, and holds SCL low until software clears the flag. The control bits that software left set at that moment decide what happens next:

- receive another byte,
- send a repeated START,
- send a STOP,
- send a STOP followed by a fresh START.

Software drives the block through a 4-bit control register and reads a data register and a status register. The bus is reached through open-drain enables: a 1 on an `_oe` output pulls that line low. The block also reads the true line levels back. It uses them to find START and STOP conditions, to time the bus-free interval before it starts a new transfer, and to see when another master wins the acknowledge slot.

Top module: `i2cmr_rx_seq`

## Requirements
- R1: After reset the status register reads F8h, `irq` is 0, the control register reads 0 and neither line enable is asserted.
- R2: With the START request bit (control bit 3) set in idle, the block waits for a free bus and then issues a START. It clears the request bit, raises the interrupt flag and posts 08h. A START issued from the wait state posts 10h instead.
- R3: While the interrupt flag (control bit 1) is set after a START or after a byte whose acknowledge slot was not lost, SCL is held low, and `irq` follows the flag.
- R4: Software can only clear the interrupt flag, by writing 0 to control bit 1. Writing 1 to that bit has no effect.
- R5: A received byte is shifted in MSB first. SDA is sampled in the middle of SCL high, and the byte appears on `rx_data` when the flag is raised.
- R6: The acknowledge-enable bit (control bit 0), read when the flag is cleared, selects the answer for the next byte. With 1, SDA is driven low in the acknowledge slot and 50h is posted. With 0, SDA is released and 58h is posted.
- R7: Clearing the flag in the wait state with only the START request set produces a repeated START and no STOP.
- R8: Clearing the flag with the STOP request bit (control bit 2) set produces a STOP, clears that bit, lowers the flag, releases both lines and posts F8h.
- R9: Clearing the flag with both request bits set produces a STOP, then a START once the bus is free, and then posts 08h.
- R10: Clearing the flag in state 58h with neither request bit set produces a STOP and returns to idle.
- R11: If SDA is sampled low during a not-acknowledge slot, the block posts 38h with both lines released. Clearing the flag then returns to idle (F8h), or, with the START request set, issues a START once the bus is free.
- R12: After a STOP is seen on the bus, no START is driven until at least FREE_CYC clock cycles have passed.
- R13: A STOP request written while idle is discarded: the bit self-clears and the bus stays untouched.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 4 | Control write value: [3] START request, [2] STOP request, [1] interrupt flag (write 0 to clear), [0] acknowledge enable |
| ctl_rdata | output | 4 | Control register read value, same layout |
| rx_data | output | 8 | Last received byte |
| status | output | 8 | Status code (F8h, 08h, 10h, 50h, 58h, 38h) |
| irq | output | 1 | Interrupt request, equal to the flag |
| scl_in | input | 1 | SCL line level |
| sda_in | input | 1 | SDA line level |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |

## Verification
Two actions meet at a single flag-clearing write when both the START and STOP request bits are set. The bench writes that combination while in state 58h and watches the bus lines on every clock. It expects exactly one STOP, then one START separated from it by at least the bus-free interval, then status 08h. A second collision occurs when the acknowledge slot is lost while a START request is already pending. It is provoked by a modelled competing master that holds SDA low through a not-acknowledge slot. The bench checks that 38h is posted with both lines released, and that clearing the flag with the START request set leads to a new START and status 08h.

// File: rtl/i2cmr_pkg.sv
package i2cmr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WFREE,
        ST_START,
        ST_WAIT,
        ST_RX,
        ST_ACK,
        ST_STOP
    } seq_st_e;

    localparam logic [7:0] CODE_IDLE    = 8'hF8;
    localparam logic [7:0] CODE_START   = 8'h08;
    localparam logic [7:0] CODE_RSTART  = 8'h10;
    localparam logic [7:0] CODE_RX_ACK  = 8'h50;
    localparam logic [7:0] CODE_RX_NACK = 8'h58;
    localparam logic [7:0] CODE_LOST    = 8'h38;

    // control register bit positions
    localparam int CB_STA  = 3;
    localparam int CB_STP  = 2;
    localparam int CB_IFLG = 1;
    localparam int CB_AAK  = 0;

    typedef struct packed {
        seq_st_e    st;
        logic [1:0] ph;
        logic [2:0] bitn;
        logic [7:0] shreg;
        logic [7:0] data;
        logic [7:0] status;
        logic       sta;
        logic       stp;
        logic       iflg;
        logic       aak;
        logic       ackb;
        logic       lost;
        logic       rep;
        logic       scl_oe;
        logic       sda_oe;
    } seq_t;

endpackage

// File: rtl/i2cmr_tick.sv
module i2cmr_tick #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt_q;

    assign tick = (cnt_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/i2cmr_busmon.sv
module i2cmr_busmon #(
    parameter int FREE_CYC = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic bus_free
);
    localparam int FW = $clog2(FREE_CYC + 1);
    localparam logic [FW-1:0] LIM = FW'(FREE_CYC);

    logic          scl_q;
    logic          sda_q;
    logic          busy_q;
    logic [FW-1:0] cnt_q;
    logic          start_evt;
    logic          stop_evt;

    // SDA edges while SCL stays high mark bus conditions
    assign start_evt = scl_q & scl_in & sda_q & ~sda_in;
    assign stop_evt  = scl_q & scl_in & ~sda_q & sda_in;
    assign bus_free  = ~busy_q & (cnt_q == LIM);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q  <= 1'b1;
            sda_q  <= 1'b1;
            busy_q <= 1'b0;
            cnt_q  <= '0;
        end else begin
            scl_q <= scl_in;
            sda_q <= sda_in;
            if (start_evt) begin
                busy_q <= 1'b1;
            end else if (stop_evt) begin
                busy_q <= 1'b0;
            end
            if (start_evt || busy_q) begin
                cnt_q <= '0;
            end else if (cnt_q != LIM) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/i2cmr_rx_seq.sv
module i2cmr_rx_seq
    import i2cmr_pkg::*;
#(
    parameter int CLK_DIV  = 4,
    parameter int FREE_CYC = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ctl_we,
    input  logic [3:0] ctl_wdata,
    output logic [3:0] ctl_rdata,
    output logic [7:0] rx_data,
    output logic [7:0] status,
    output logic       irq,
    input  logic       scl_in,
    input  logic       sda_in,
    output logic       scl_oe,
    output logic       sda_oe
);
    seq_t q, d;
    logic tick;
    logic bus_free;

    i2cmr_tick #(.DIV(CLK_DIV)) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (tick)
    );

    i2cmr_busmon #(.FREE_CYC(FREE_CYC)) u_busmon (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl_in  (scl_in),
        .sda_in  (sda_in),
        .bus_free(bus_free)
    );

    // {scl_oe, sda_oe} for a state and quarter phase
    function automatic logic [1:0] line_drv(seq_st_e s, logic [1:0] ph,
                                            logic ackb, logic lost);
        logic [1:0] r;
        case (s)
            ST_WAIT:  r = lost ? 2'b00 : 2'b11;
            ST_START: r = (ph == 2'd0) ? 2'b10 : (ph == 2'd1) ? 2'b00 : 2'b01;
            ST_RX:    r = (ph < 2'd2) ? 2'b10 : 2'b00;
            ST_ACK:   r = {(ph < 2'd2), ackb};
            ST_STOP:  r = (ph == 2'd0) ? 2'b11 : (ph == 2'd1) ? 2'b01 : 2'b00;
            default:  r = 2'b00;
        endcase
        return r;
    endfunction

    always_comb begin
        d = q;
        if (ctl_we) begin
            d.sta = ctl_wdata[CB_STA];
            d.stp = ctl_wdata[CB_STP];
            d.aak = ctl_wdata[CB_AAK];
            if (!ctl_wdata[CB_IFLG]) begin
                d.iflg = 1'b0;
            end
        end
        case (q.st)
            ST_IDLE: begin
                d.status = CODE_IDLE;
                if (q.sta) begin
                    d.st = ST_WFREE;
                end else if (q.stp) begin
                    d.stp = 1'b0;
                end
            end
            ST_WFREE: begin
                if (bus_free) begin
                    d.st  = ST_START;
                    d.ph  = 2'd1;
                    d.rep = 1'b0;
                end
            end
            ST_START: begin
                if (tick) begin
                    d.ph = q.ph + 2'd1;
                    if (q.ph == 2'd3) begin
                        d.st     = ST_WAIT;
                        d.iflg   = 1'b1;
                        d.sta    = 1'b0;
                        d.status = q.rep ? CODE_RSTART : CODE_START;
                    end
                end
            end
            ST_WAIT: begin
                if (!q.iflg) begin
                    d.ph = 2'd0;
                    if (q.lost) begin
                        d.lost   = 1'b0;
                        d.status = CODE_IDLE;
                        d.st     = q.sta ? ST_WFREE : ST_IDLE;
                    end else if (q.stp || (!q.sta && q.status == CODE_RX_NACK)) begin
                        d.st = ST_STOP;
                    end else if (q.sta) begin
                        d.st  = ST_START;
                        d.rep = 1'b1;
                    end else begin
                        d.st   = ST_RX;
                        d.bitn = 3'd0;
                        d.ackb = q.aak;
                    end
                end
            end
            ST_RX: begin
                if (tick) begin
                    d.ph = q.ph + 2'd1;
                    if (q.ph == 2'd2) begin
                        d.shreg = {q.shreg[6:0], sda_in};
                    end
                    if (q.ph == 2'd3) begin
                        if (q.bitn == 3'd7) begin
                            d.st = ST_ACK;
                        end else begin
                            d.bitn = q.bitn + 3'd1;
                        end
                    end
                end
            end
            ST_ACK: begin
                if (tick) begin
                    d.ph = q.ph + 2'd1;
                    if (q.ph == 2'd2 && !q.ackb && !sda_in) begin
                        d.lost = 1'b1;
                    end
                    if (q.ph == 2'd3) begin
                        d.st     = ST_WAIT;
                        d.iflg   = 1'b1;
                        d.data   = q.shreg;
                        d.status = q.lost ? CODE_LOST :
                                   (q.ackb ? CODE_RX_ACK : CODE_RX_NACK);
                    end
                end
            end
            ST_STOP: begin
                if (tick) begin
                    d.ph = q.ph + 2'd1;
                    if (q.ph == 2'd3) begin
                        d.stp    = 1'b0;
                        d.status = CODE_IDLE;
                        d.st     = q.sta ? ST_WFREE : ST_IDLE;
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase
        {d.scl_oe, d.sda_oe} = line_drv(d.st, d.ph, d.ackb, d.lost);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q        <= '0;
            q.status <= CODE_IDLE;
        end else begin
            q <= d;
        end
    end

    assign ctl_rdata = {q.sta, q.stp, q.iflg, q.aak};
    assign rx_data   = q.data;
    assign status    = q.status;
    assign irq       = q.iflg;
    assign scl_oe    = q.scl_oe;
    assign sda_oe    = q.sda_oe;
endmodule

// File: rtl/i2cmr_rx_seq_chk.sv
module i2cmr_rx_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       ctl_we,
    input logic [3:0] ctl_wdata,
    input logic [7:0] status,
    input logic       irq,
    input logic       scl_oe,
    input logic       sda_oe
);
    p_post_code_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> (status inside {8'h08, 8'h10, 8'h50, 8'h58, 8'h38}));

    p_hold_scl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && status != 8'h38) |-> scl_oe);

    p_iflg_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && ctl_we && !ctl_wdata[1]) |=> !irq);

    p_ack_drive_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(irq) && status == 8'h50) |-> $past(sda_oe));

    p_nack_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(irq) && status == 8'h58) |-> !$past(sda_oe));

    p_lost_release_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && status == 8'h38) |-> (!scl_oe && !sda_oe));
endmodule

bind i2cmr_rx_seq i2cmr_rx_seq_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ctl_we   (ctl_we),
    .ctl_wdata(ctl_wdata),
    .status   (status),
    .irq      (irq),
    .scl_oe   (scl_oe),
    .sda_oe   (sda_oe)
);

// File: tb/i2cmr_rx_seq_tb_top.sv
`timescale 1ns/1ps
module i2cmr_rx_seq_tb_top;
    localparam int FREE_CYC = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctl_we = 1'b0;
    logic [3:0] ctl_wdata = 4'h0;
    logic [3:0] ctl_rdata;
    logic [7:0] rx_data;
    logic [7:0] status;
    logic       irq, scl_oe, sda_oe;
    logic       scl_bus, sda_bus, slv_low;

    int vectors = 0;
    int miscmp = 0;
    int neg_cnt = 0;
    int slv_base = 0;
    bit slv_on = 1'b0;
    bit slv_ack_low = 1'b0;
    logic [7:0] slv_byte = 8'h00;
    int cyc = 0, start_cnt = 0, stop_cnt = 0, start_cyc = 0, stop_cyc = 0;
    logic scl_p = 1'b1, sda_p = 1'b1;

    always #2.5 clk = ~clk;

    assign scl_bus = ~scl_oe;
    assign sda_bus = ~(sda_oe | slv_low);

    i2cmr_rx_seq #(.CLK_DIV(4), .FREE_CYC(FREE_CYC)) dut_i (
        .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
        .ctl_rdata(ctl_rdata), .rx_data(rx_data), .status(status), .irq(irq),
        .scl_in(scl_bus), .sda_in(sda_bus), .scl_oe(scl_oe), .sda_oe(sda_oe)
    );

    // transmitting slave: bit k of the byte appears after k SCL falls
    always @(negedge scl_bus) neg_cnt++;

    always_comb begin
        int k;
        k = neg_cnt - slv_base;
        if (!slv_on)     slv_low = 1'b0;
        else if (k < 8)  slv_low = ~slv_byte[7-k];
        else if (k == 8) slv_low = slv_ack_low;
        else             slv_low = 1'b0;
    end

    // bus condition monitor
    always @(negedge clk) begin
        cyc++;
        if (scl_p && scl_bus && sda_p && !sda_bus) begin start_cnt++; start_cyc = cyc; end
        if (scl_p && scl_bus && !sda_p && sda_bus) begin stop_cnt++;  stop_cyc = cyc;  end
        scl_p = scl_bus;
        sda_p = sda_bus;
    end

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscmp++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic wr_ctl(logic [3:0] v);
        @(negedge clk); ctl_we = 1'b1; ctl_wdata = v;
        @(negedge clk); ctl_we = 1'b0;
    endtask

    task automatic wait_irq(string req);
        int n = 0;
        while (!irq && n < 3000) begin @(negedge clk); n++; end
        chk(req, "irq raised", irq, 1);
    endtask

    task automatic wait_idle(string req);
        int n = 0;
        while (status !== 8'hF8 && n < 3000) begin @(negedge clk); n++; end
        repeat (4) @(negedge clk);
        chk(req, "idle status", status, 8'hF8);
    endtask

    task automatic arm(logic [7:0] b, bit ack_low);
        slv_byte = b; slv_ack_low = ack_low; slv_base = neg_cnt; slv_on = 1'b1;
    endtask

    task automatic t_reset;
        chk("R1", "status", status, 8'hF8);
        chk("R1", "irq", irq, 0);
        chk("R1", "ctl", ctl_rdata, 0);
        chk("R1", "lines", {scl_oe, sda_oe}, 0);
    endtask

    task automatic t_idle_writes;
        wr_ctl(4'h4);
        repeat (20) @(negedge clk);
        chk("R13", "stp self-clear", ctl_rdata[2], 0);
        chk("R13", "no bus activity", start_cnt + stop_cnt, 0);
        chk("R13", "lines idle", {scl_oe, sda_oe}, 0);
        wr_ctl(4'h2);
        repeat (3) @(negedge clk);
        chk("R4", "flag not settable", {irq, ctl_rdata[1]}, 0);
    endtask

    task automatic t_start;
        int s0 = start_cnt;
        wr_ctl(4'h8);
        wait_irq("R2");
        chk("R2", "status start", status, 8'h08);
        chk("R2", "sta cleared", ctl_rdata[3], 0);
        chk("R2", "one start", start_cnt, s0 + 1);
        repeat (60) @(negedge clk);
        chk("R3", "held irq", irq, 1);
        chk("R3", "scl held low", scl_bus, 0);
    endtask

    task automatic t_rx(logic [7:0] b, bit ack);
        arm(b, 1'b0);
        wr_ctl(ack ? 4'h1 : 4'h0);
        wait_irq("R5");
        chk("R5", "rx data", rx_data, b);
        chk("R6", "ack status", status, ack ? 8'h50 : 8'h58);
        chk("R3", "flag bit", ctl_rdata[1], 1);
        chk("R3", "scl low", scl_bus, 0);
    endtask

    task automatic t_rep_start;
        int s0 = start_cnt, p0 = stop_cnt;
        wr_ctl(4'h8);
        wait_irq("R7");
        chk("R7", "status rstart", status, 8'h10);
        chk("R7", "start seen", start_cnt, s0 + 1);
        chk("R7", "no stop", stop_cnt, p0);
    endtask

    task automatic t_stop;
        int p0 = stop_cnt;
        wr_ctl(4'h4);
        wait_idle("R8");
        chk("R8", "stop seen", stop_cnt, p0 + 1);
        chk("R8", "stp cleared", ctl_rdata[2], 0);
        chk("R8", "irq low", irq, 0);
        chk("R8", "lines released", {scl_oe, sda_oe}, 0);
    endtask

    task automatic t_stop_start;
        int s0 = start_cnt, p0 = stop_cnt;
        wr_ctl(4'hC);
        wait_irq("R9");
        chk("R9", "status start", status, 8'h08);
        chk("R9", "stop seen", stop_cnt, p0 + 1);
        chk("R9", "start seen", start_cnt, s0 + 1);
        chk("R12", "free gap", (start_cyc - stop_cyc) >= FREE_CYC, 1);
    endtask

    task automatic t_neither;
        int p0 = stop_cnt;
        wr_ctl(4'h0);
        wait_idle("R10");
        chk("R10", "stop seen", stop_cnt, p0 + 1);
        chk("R10", "irq low", irq, 0);
    endtask

    task automatic t_lost(bit restart);
        int s0;
        arm(8'h7E, 1'b1);
        wr_ctl(4'h0);
        wait_irq("R11");
        chk("R11", "status lost", status, 8'h38);
        chk("R11", "lines released", {scl_oe, sda_oe}, 0);
        chk("R11", "rx data", rx_data, 8'h7E);
        slv_on = 1'b0;
        repeat (5) @(negedge clk);
        s0 = start_cnt;
        if (restart) begin
            wr_ctl(4'h8);
            wait_irq("R11");
            chk("R11", "restart status", status, 8'h08);
            chk("R11", "restart seen", start_cnt, s0 + 1);
        end else begin
            wr_ctl(4'h0);
            wait_idle("R11");
            chk("R11", "irq low", irq, 0);
            chk("R11", "no start", start_cnt, s0);
        end
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_idle_writes();
        t_start();
        t_rx(8'hA5, 1'b1);
        t_rx(8'h3C, 1'b0);
        t_rep_start();
        t_rx(8'h81, 1'b0);
        t_stop();
        t_start();
        t_rx(8'h5A, 1'b0);
        t_stop_start();
        t_rx(8'hC3, 1'b0);
        t_neither();
        t_start();
        t_lost(1'b0);
        t_start();
        t_lost(1'b1);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        vectors++;
        miscmp++;
        $display("FAIL watchdog: actual running expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
        $finish;
    end
endmodule